// File: doc/BRIEF.md
# Trace Address Squeeze Encoder

This block shortens an instruction address before it goes into a variable-length trace field. The field's transport carries six payload bits per byte and leaves out leading zero bits. Instruction addresses are always even, so bit 0 is never sent. Kernel addresses in a 64-bit space carry long runs of leading ones, and a zero-only trim cannot shorten them.

With the squeeze enable set, the encoder also removes runs of identical high bits, six at a time. It then pads the kept value upward with copies of its top kept bit. A decoder rebuilds the address by sign-extending from the top bit of the field.

Each accepted address gives one result, registered one cycle later. The result has three parts: the shortened value, its significant bit width, and the number of six-bit slices needed to carry that width. Both sides use a valid/ready handshake. The address width is a parameter, 64 by default or 32.

Top module: `trace_addr_squeeze`

## Requirements
- R1: Address bit 0 is never part of the result. With the squeeze enable low, `out_value` equals the address shifted right by one. `out_width` is the index of the highest set bit of that value plus one, and 0 for a zero value. For example, 0xFFFF_FFFF_8000_31F4 gives 0x7FFF_FFFF_C000_18FA with a width of 63.
- R2: With the squeeze enable high, a scan index i starts at XLEN-1. While i > 6, the scan compares address bits i down to i-5 against bit i-6. If all six match, i decreases by 6 and the scan continues. Otherwise the scan stops.
- R3: If the scan stopped below XLEN-1, the result is built as follows:
  - value bits i-1..0 hold address bits i..1;
  - the next p = (i-1) mod 6 bits above them copy address bit i;
  - the width is i+p;
  - every value bit at or above the width is 0.
- R4: With the squeeze enable high and no bits removed, the value is the address shifted right by one and the width is XLEN-1.
- R5: `out_slices` is the width divided by 6, rounded up, with a minimum of 1.
- R6: Take the value and sign-extend it from bit width-1 (squeeze on) or zero-extend it (squeeze off). Shifting that left by one gives back the address with bit 0 cleared.
- R7: `in_ready` is high when no result is held or the held result is being taken. An accepted address gives `out_valid` on the next cycle. A result is held unchanged while `out_ready` is low.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: With squeeze on, 0xFFFF_FFFE_3FFF_FFFE encodes to 0x7_1FFF_FFFF with a width of 35 and 6 slices. It must not encode to 0x1FFF_FFFF, which would decode to a wrong address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Encoder can take an address this cycle |
| in_addr | input | XLEN | Instruction address |
| in_squeeze_en | input | 1 | Enables removal of identical high bits |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | XLEN-1 | Shortened field value |
| out_width | output | $clog2(XLEN+1) | Significant bits in the value |
| out_slices | output | $clog2((XLEN-1)/6+2) | Six-bit slices needed |

## Verification
The only internal state is the output register, so a wrong scan result or pad length shows up at the ports on the cycle after the address is accepted. It appears as a width that breaks the slice count, as set bits above the width, or as a round-trip decode that does not give back the address. A corrupted valid flag shows within one cycle: a result is lost or repeated, so the scoreboard queue runs out of step with the outputs. A held result that changes while stalled is caught at the next sample.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned TSC_SLICE_W = 6;

  // slices needed to carry w bits, never fewer than one
  function automatic int tsc_slices(input int w, input int s);
    int n;
    n = (w + s - 1) / s;
    return (n < 1) ? 1 : n;
  endfunction
endpackage

// File: rtl/tsc_run_scan.sv
module tsc_run_scan #(
  parameter int XLEN    = 64,
  parameter int SLICE_W = 6,
  parameter int NCHK    = 10,
  parameter int SW      = 4,
  parameter int WW      = 7
) (
  input  logic [XLEN-1:0] addr,
  output logic [SW-1:0]   steps,
  output logic [WW-1:0]   stop_idx
);
  localparam int LO = XLEN - 1 - SLICE_W * NCHK;

  logic [NCHK-1:0] same;
  logic            unused_tail;
  int              cnt;
  logic            run;

  assign unused_tail = ^addr[LO-1:0];

  // one window compare per possible step
  for (genvar k = 0; k < NCHK; k++) begin : g_win
    localparam int HI = XLEN - 1 - SLICE_W * k;
    assign same[k] = (addr[HI -: SLICE_W] == {SLICE_W{addr[HI-SLICE_W]}});
  end

  // the run of matching windows from the top ends at the first mismatch
  always_comb begin
    cnt = 0;
    run = 1'b1;
    for (int k = 0; k < NCHK; k++) begin
      if (run && same[k]) cnt = cnt + 1;
      else                run = 1'b0;
    end
    steps    = SW'(cnt);
    stop_idx = WW'(XLEN - 1 - SLICE_W * cnt);
  end
endmodule

// File: rtl/tsc_msb_find.sv
module tsc_msb_find #(
  parameter int VW = 63,
  parameter int WW = 7
) (
  input  logic [VW-1:0] vec,
  output logic [WW-1:0] width
);
  always_comb begin
    width = '0;
    for (int b = 0; b < VW; b++) begin
      if (vec[b]) width = WW'(b + 1);
    end
  end
endmodule

// File: rtl/tsc_pack.sv
module tsc_pack #(
  parameter int XLEN    = 64,
  parameter int SLICE_W = 6,
  parameter int SW      = 4,
  parameter int WW      = 7,
  parameter int CW      = 4
) (
  input  logic [XLEN-1:0] addr,
  input  logic            squeeze_en,
  input  logic [SW-1:0]   steps,
  input  logic [WW-1:0]   stop_idx,
  input  logic [WW-1:0]   zero_width,
  output logic [XLEN-2:0] value,
  output logic [WW-1:0]   width,
  output logic [CW-1:0]   slices
);
  import tsc_pkg::*;
  localparam int VW = XLEN - 1;

  logic [VW-1:0] shifted;
  logic [VW-1:0] trimmed;
  logic          sgn;
  logic          unused_bit0;
  int            idx;
  int            pad;
  int            top_w;

  assign shifted     = addr[XLEN-1:1];
  assign unused_bit0 = addr[0];

  // keep bits below the stop index, then pad with the bit at the stop index
  always_comb begin
    idx   = int'(stop_idx);
    pad   = (idx - 1) % SLICE_W;
    top_w = idx + pad;
    sgn   = 1'b0;
    for (int b = 0; b < XLEN; b++) begin
      if (b == idx) sgn = addr[b];
    end
    trimmed = '0;
    for (int b = 0; b < VW; b++) begin
      if (b < idx)        trimmed[b] = addr[b+1];
      else if (b < top_w) trimmed[b] = sgn;
    end
  end

  always_comb begin
    if (!squeeze_en) begin
      value = shifted;
      width = zero_width;
    end else if (steps == '0) begin
      value = shifted;
      width = WW'(VW);
    end else begin
      value = trimmed;
      width = WW'(top_w);
    end
  end

  always_comb slices = CW'(tsc_slices(int'(width), SLICE_W));
endmodule

// File: rtl/trace_addr_squeeze.sv
module trace_addr_squeeze #(
  parameter int XLEN    = 64,
  parameter int SLICE_W = tsc_pkg::TSC_SLICE_W,
  parameter int VW      = XLEN - 1,
  parameter int WW      = $clog2(XLEN + 1),
  parameter int CW      = $clog2(VW / SLICE_W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XLEN-1:0] in_addr,
  input  logic          in_squeeze_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_value,
  output logic [WW-1:0] out_width,
  output logic [CW-1:0] out_slices
);
  localparam int NCHK = (XLEN - 2) / SLICE_W;
  localparam int SW   = $clog2(NCHK + 1);

  logic [SW-1:0] steps;
  logic [WW-1:0] stop_idx;
  logic [WW-1:0] zero_width;
  logic [VW-1:0] value_c;
  logic [WW-1:0] width_c;
  logic [CW-1:0] slices_c;

  logic          vld_q, vld_d;
  logic          take;
  logic [VW-1:0] value_q;
  logic [WW-1:0] width_q;
  logic [CW-1:0] slices_q;

  tsc_run_scan #(.XLEN(XLEN), .SLICE_W(SLICE_W), .NCHK(NCHK), .SW(SW), .WW(WW)) scan_i (
    .addr(in_addr), .steps(steps), .stop_idx(stop_idx)
  );

  tsc_msb_find #(.VW(VW), .WW(WW)) msb_i (
    .vec(in_addr[XLEN-1:1]), .width(zero_width)
  );

  tsc_pack #(.XLEN(XLEN), .SLICE_W(SLICE_W), .SW(SW), .WW(WW), .CW(CW)) pack_i (
    .addr(in_addr), .squeeze_en(in_squeeze_en), .steps(steps), .stop_idx(stop_idx),
    .zero_width(zero_width), .value(value_c), .width(width_c), .slices(slices_c)
  );

  // output stage: next state
  always_comb begin
    in_ready = !vld_q || out_ready;
    take     = in_valid && in_ready;
    if (take)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // data registers carry no reset and load only on accept
  always_ff @(posedge clk) begin
    if (take) begin
      value_q  <= value_c;
      width_q  <= width_c;
      slices_q <= slices_c;
    end
  end

  assign out_valid  = vld_q;
  assign out_value  = value_q;
  assign out_width  = width_q;
  assign out_slices = slices_q;

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_width)
                                && $stable(out_slices));

  assert_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_value >> out_width) == '0));

  assert_slices_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_slices != '0) && (int'(out_slices) * SLICE_W >= int'(out_width))
                  && ((int'(out_slices) - 1) * SLICE_W < int'(out_width) || out_slices == 1));

  assert_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_width) <= VW);
endmodule

// File: tb/trace_addr_squeeze_tb_top.sv
module trace_addr_squeeze_tb_top;
  localparam int XLEN = 64;
  localparam int VW   = XLEN - 1;
  localparam int WW   = $clog2(XLEN + 1);
  localparam int CW   = $clog2(VW / 6 + 2);

  typedef struct {
    logic [XLEN-1:0] addr;
    logic            en;
    logic [VW-1:0]   val;
    int              w;
    int              sl;
    string           tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [XLEN-1:0] in_addr;
  logic            in_squeeze_en;
  logic            out_valid;
  logic            out_ready;
  logic [VW-1:0]   out_value;
  logic [WW-1:0]   out_width;
  logic [CW-1:0]   out_slices;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    stall_on = 1'b0;
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  trace_addr_squeeze #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_squeeze_en(in_squeeze_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_value(out_value), .out_width(out_width),
    .out_slices(out_slices)
  );

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected result computed from the requirement text
  task automatic model(input logic [XLEN-1:0] a, input logic en,
                       output logic [VW-1:0] v, output int w, output int sl);
    int i;
    int p;
    v = a[XLEN-1:1];
    w = 0;
    if (!en) begin
      for (int b = 0; b < VW; b++) if (v[b]) w = b + 1;
    end else begin
      i = XLEN - 1;
      while (i > 6 && a[i -: 6] == {6{a[i-6]}}) i = i - 6;
      if (i == XLEN - 1) w = VW;
      else begin
        p = (i - 1) % 6;
        v = '0;
        for (int b = 0; b < i; b++) v[b] = a[b+1];
        for (int b = i; b < i + p; b++) v[b] = a[i];
        w = i + p;
      end
    end
    sl = (w + 5) / 6;
    if (sl < 1) sl = 1;
  endtask

  function automatic logic [XLEN-1:0] decode(input logic [VW-1:0] v, input int w,
                                             input logic en);
    logic [XLEN-1:0] ext;
    ext = {1'b0, v};
    if (en && w > 0)
      for (int b = w; b < XLEN; b++) ext[b] = v[w-1];
    return {ext[XLEN-2:0], 1'b0};
  endfunction

  task automatic push_send(input logic [XLEN-1:0] a, input logic en, input logic [VW-1:0] v,
                           input int w, input int sl, input string tag);
    item_t it;
    in_valid      = 1'b1;
    in_addr       = a;
    in_squeeze_en = en;
    while (!in_ready) @(negedge clk);
    it.addr = a; it.en = en; it.val = v; it.w = w; it.sl = sl; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_model(input logic [XLEN-1:0] a, input logic en);
    logic [VW-1:0] v;
    int w;
    int sl;
    model(a, en, v, w, sl);
    push_send(a, en, v, w, sl, "R2/R3");
  endtask

  // consumer ready pattern, changed away from both edges
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      out_ready = stall_on ? 1'($urandom % 2) : 1'b1;
    end
  end

  // monitor: compare results in order, and check held results
  initial begin
    item_t it;
    bit            held = 1'b0;
    logic [VW-1:0] hv;
    int            hw;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held)
          chk(out_valid && out_value == hv && int'(out_width) == hw, "R7 held result",
              {1'b0, out_value}, {1'b0, hv});
        held = out_valid && !out_ready;
        hv   = out_value;
        hw   = int'(out_width);
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R7 unexpected result", {1'b0, out_value}, '0);
          end else begin
            it = q.pop_front();
            chk(out_value == it.val, {it.tag, " value"}, {1'b0, out_value}, {1'b0, it.val});
            chk(int'(out_width) == it.w, {it.tag, " width"}, XLEN'(out_width), XLEN'(it.w));
            chk(int'(out_slices) == it.sl, "R5 slices", XLEN'(out_slices), XLEN'(it.sl));
            chk(decode(out_value, int'(out_width), it.en) == {it.addr[XLEN-1:1], 1'b0},
                "R6 round trip", decode(out_value, int'(out_width), it.en),
                {it.addr[XLEN-1:1], 1'b0});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] a;
    int k;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr = '0;
    in_squeeze_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R8 out_valid after reset", XLEN'(out_valid), 0);
    chk(in_ready, "R8 in_ready after reset", XLEN'(in_ready), 1);

    // R1: plain trim, bit 0 dropped
    push_send(64'hFFFF_FFFF_8000_31F4, 1'b0, 63'h7FFF_FFFF_C000_18FA, 63, 11, "R1");
    push_send(64'h0000_0000_0000_0003, 1'b0, 63'h1, 1, 1, "R1");
    push_send(64'h0000_0000_0000_1000, 1'b0, 63'h800, 12, 2, "R1");
    push_send(64'h0, 1'b0, 63'h0, 0, 1, "R1");
    // R2/R3: squeezed kernel address
    push_send(64'hFFFF_FFFF_8000_31F4, 1'b1, 63'h7_C000_18FA, 35, 6, "R3");
    push_send(64'h0000_0000_0000_1000, 1'b1, 63'h800, 17, 3, "R3");
    push_send(64'h0, 1'b1, 63'h0, 5, 1, "R2");
    push_send(64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 63'h1F, 5, 1, "R2");
    // R4: nothing removable
    push_send(64'h8000_0000_0000_0000, 1'b1, 63'h4000_0000_0000_0000, 63, 11, "R4");
    // R9: known naive-rule failure
    push_send(64'hFFFF_FFFE_3FFF_FFFE, 1'b1, 63'h7_1FFF_FFFF, 35, 6, "R9");

    // random sign-extended addresses with consumer stalls (R7)
    stall_on = 1'b1;
    for (int n = 0; n < 300; n++) begin
      a = {$urandom, $urandom};
      k = $urandom % XLEN;
      for (int b = k + 1; b < XLEN; b++) a[b] = a[k];
      a[0] = 1'b0;
      send_model(a, 1'($urandom % 2));
    end
    stall_on = 1'b0;
    for (int n = 0; n < 100; n++) begin
      a = {$urandom, $urandom};
      send_model(a, 1'($urandom % 2));
    end

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!out_valid, "R7 no extra result", XLEN'(out_valid), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule